// File: doc/BRIEF.md
# I2C SCL Half-Period Timing Generator

This block paces the clock line of an I2C master. A source tick, already divided down from the system clock, drives two nested down-counters: an inner step counter and an outer sample counter. One SCL half-period lasts (sample count × step count) source ticks, so the bus rate is the tick rate divided by twice that product. The transaction sequencer raises `run` to get clock pulses and gets a one-cycle strobe at every SCL edge: `fall_stb` marks the point where data may be driven, and `rise_stb` marks the point where data is about to be sampled.

Two timing words set the counts. The normal word serves standard and fast mode. The high-speed word is used only when its enable key is present and the sequencer signals, through `hs_phase`, that the high-speed part of a transfer is in progress. The mode is chosen again at the start of every half-period. Both words and the rate selector are captured only while the generator is idle, so a software write during a transfer never shortens or stretches a running phase. The generator also publishes the start-condition hold word that matches the selected rate.

The control state machine has three states. IDLE holds SCL high, tracks the inputs, and moves to HIGH when `run` is seen. HIGH counts a high half-period. On expiry it moves to LOW with a fall strobe if `run` is still set, and otherwise returns to IDLE without a strobe. LOW counts a low half-period. On expiry it always produces a rise strobe, then moves to HIGH if `run` is set and to IDLE if it is not. Every move into HIGH or LOW reloads both counters from the selected fields.

Top module: `i2c_scl_timegen`

## Requirements
- R1: While reset is held: `scl_o`=1, `busy`=0, `rise_stb`=0, `fall_stb`=0, `hs_armed`=0 and `start_cfg`=16'h1800.
- R2: In normal mode each half-period lasts (S+1)×(T+1) source ticks, with S = `norm_timing`[10:8] and T = `norm_timing`[5:0]. The first half-period after `run` is seen is a high one.
- R3: `fall_stb` pulses for one cycle in the cycle in which `scl_o` goes low, and `rise_stb` pulses in the cycle in which it goes high. The two never pulse together, and `scl_o` never changes without one of them.
- R4: High-speed timing is armed, and `hs_armed`=1, when `hs_timing`[1:0]=2'b11. A value of 0 in those bits disarms it. When armed and `hs_phase`=1, a half-period lasts (P+1)×(Q+1) ticks, with P = `hs_timing`[14:12] and Q = `hs_timing`[10:8]. Otherwise the normal fields apply.
- R5: The mode is chosen when a half-period starts. A change of `hs_phase` during a half-period first affects the next one.
- R6: While `busy`=1, changes to `norm_timing`, `hs_timing` or `rate_std` have no effect on phase lengths or on `start_cfg`. They take effect once the generator is idle.
- R7: If `run` is dropped during a low half-period, that half-period completes, `rise_stb` pulses and the generator goes idle with SCL high. If `run` is dropped during a high half-period, that half-period completes and the generator goes idle with no strobe.
- R8: `start_cfg` is 16'h8001 when `rate_std`=1 (rates up to 100 kHz) and 16'h1800 otherwise. It follows the input one clock later while idle.
- R9: The counters advance only in cycles with `src_tick`=1, so a half-period lasts N × (tick spacing) clock cycles.
- R10: The extreme counts work: 1×1 gives one tick per half-period, and 8×64 gives 512 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | Divided source tick enable |
| run | input | 1 | Sequencer request for SCL pulses |
| hs_phase | input | 1 | Sequencer is in the high-speed part of a transfer |
| rate_std | input | 1 | 1 selects the standard-rate start hold word |
| norm_timing | input | 16 | Normal timing word (count−1 fields) |
| hs_timing | input | 16 | High-speed timing word (count−1 fields, enable key) |
| scl_o | output | 1 | SCL level request, 1 = released high |
| rise_stb | output | 1 | One-cycle strobe at SCL rising |
| fall_stb | output | 1 | One-cycle strobe at SCL falling |
| busy | output | 1 | Generator is outside IDLE |
| hs_armed | output | 1 | Captured high-speed word carries the enable key |
| start_cfg | output | 16 | Start-condition hold word for the captured rate |

## Verification
`busy` rises one clock after `run` is sampled. `scl_o` and its strobe change at the clock edge that consumes the N-th tick of a half-period. `start_cfg` and `hs_armed` follow their inputs one edge after a change while idle. The driver task pushes the expected strobe kind and half-period length, in clock cycles, for each edge. The monitor samples on the falling clock edge and counts cycles from one strobe to the next, so every length is compared exactly where the edge is due. When the tick spacing makes the length of the first phase depend on alignment, that one length is marked don't-care. Idle-time captures are checked on the second falling edge after the input change, and the absence of a strobe is checked by requiring an empty queue once the generator is idle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } scl_state_t;

    localparam int CFG_W = 16;
    localparam logic [CFG_W-1:0] HOLD_STD  = 16'h8001;
    localparam logic [CFG_W-1:0] HOLD_FAST = 16'h1800;
    localparam logic [1:0]       HS_KEY    = 2'b11;

endpackage

// File: rtl/scl_timing_shadow.sv
module scl_timing_shadow
    import scl_gen_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int SAMP_W     = 3,
    parameter int STEP_W     = 6,
    parameter int HS_STEP_W  = 3,
    parameter int N_SAMP_LSB = 8,
    parameter int N_STEP_LSB = 0,
    parameter int H_SAMP_LSB = 12,
    parameter int H_STEP_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              hs_phase,
    input  logic              rate_std_in,
    input  logic [REG_W-1:0]  norm_in,
    input  logic [REG_W-1:0]  hs_in,
    output logic [SAMP_W-1:0] samp_m1,
    output logic [STEP_W-1:0] step_m1,
    output logic              hs_armed,
    output logic [CFG_W-1:0]  start_cfg
);

    localparam logic [REG_W-1:0] NORM_MASK =
        REG_W'(((1 << SAMP_W) - 1) << N_SAMP_LSB) |
        REG_W'(((1 << STEP_W) - 1) << N_STEP_LSB);
    localparam logic [REG_W-1:0] HS_MASK =
        REG_W'(((1 << SAMP_W) - 1) << H_SAMP_LSB) |
        REG_W'(((1 << HS_STEP_W) - 1) << H_STEP_LSB) | REG_W'(3);

    // captured copies
    logic [SAMP_W-1:0]    n_samp_q, h_samp_q;
    logic [STEP_W-1:0]    n_step_q;
    logic [HS_STEP_W-1:0] h_step_q;
    logic                 h_arm_q, std_q;

    // decoded live inputs
    logic [SAMP_W-1:0]    in_n_samp, in_h_samp;
    logic [STEP_W-1:0]    in_n_step;
    logic [HS_STEP_W-1:0] in_h_step;
    logic                 in_h_arm;

    // effective view used for the next counter load
    logic [SAMP_W-1:0]    eff_n_samp, eff_h_samp;
    logic [STEP_W-1:0]    eff_n_step, eff_h_step_ext;
    logic [HS_STEP_W-1:0] eff_h_step;
    logic                 eff_h_arm;

    logic unused_bits;
    assign unused_bits = ^{norm_in & ~NORM_MASK, hs_in & ~HS_MASK};

    always_comb begin
        in_n_samp = norm_in[N_SAMP_LSB +: SAMP_W];
        in_n_step = norm_in[N_STEP_LSB +: STEP_W];
        in_h_samp = hs_in[H_SAMP_LSB +: SAMP_W];
        in_h_step = hs_in[H_STEP_LSB +: HS_STEP_W];
        in_h_arm  = (hs_in[1:0] == HS_KEY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_samp_q <= '0;
            n_step_q <= '0;
            h_samp_q <= '0;
            h_step_q <= '0;
            h_arm_q  <= 1'b0;
            std_q    <= 1'b0;
        end else if (capture) begin
            n_samp_q <= in_n_samp;
            n_step_q <= in_n_step;
            h_samp_q <= in_h_samp;
            h_step_q <= in_h_step;
            h_arm_q  <= in_h_arm;
            std_q    <= rate_std_in;
        end
    end

    always_comb begin
        eff_n_samp = capture ? in_n_samp : n_samp_q;
        eff_n_step = capture ? in_n_step : n_step_q;
        eff_h_samp = capture ? in_h_samp : h_samp_q;
        eff_h_step = capture ? in_h_step : h_step_q;
        eff_h_arm  = capture ? in_h_arm  : h_arm_q;
    end

    generate
        if (STEP_W > HS_STEP_W) begin : g_hs_pad
            assign eff_h_step_ext = {{(STEP_W-HS_STEP_W){1'b0}}, eff_h_step};
        end else begin : g_hs_trim
            assign eff_h_step_ext = eff_h_step[STEP_W-1:0];
        end
    endgenerate

    always_comb begin
        if (eff_h_arm && hs_phase) begin
            samp_m1 = eff_h_samp;
            step_m1 = eff_h_step_ext;
        end else begin
            samp_m1 = eff_n_samp;
            step_m1 = eff_n_step;
        end
    end

    assign hs_armed  = h_arm_q;
    assign start_cfg = std_q ? HOLD_STD : HOLD_FAST;

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> ($stable(n_samp_q) && $stable(n_step_q) && $stable(h_samp_q)
                             && $stable(h_step_q) && $stable(h_arm_q) && $stable(std_q))); // R6

    AST_HOLD_WORD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cfg == HOLD_STD) || (start_cfg == HOLD_FAST)); // R8

endmodule

// File: rtl/scl_half_counter.sv
module scl_half_counter #(
    parameter int SAMP_W = 3,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [SAMP_W-1:0] samp_m1,
    input  logic [STEP_W-1:0] step_m1,
    output logic              expire
);

    logic [SAMP_W-1:0] samp_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_rel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q     <= '0;
            step_q     <= '0;
            step_rel_q <= '0;
        end else if (load) begin
            samp_q     <= samp_m1;
            step_q     <= step_m1;
            step_rel_q <= step_m1;
        end else if (tick) begin
            if (step_q == '0) begin
                step_q <= step_rel_q;
                if (samp_q != '0) begin
                    samp_q <= samp_q - 1'b1;
                end
            end else begin
                step_q <= step_q - 1'b1;
            end
        end
    end

    assign expire = tick && (samp_q == '0) && (step_q == '0);

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= step_rel_q); // R2

endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen
    import scl_gen_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int SAMP_W    = 3,
    parameter int STEP_W    = 6,
    parameter int HS_STEP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             run,
    input  logic             hs_phase,
    input  logic             rate_std,
    input  logic [REG_W-1:0] norm_timing,
    input  logic [REG_W-1:0] hs_timing,
    output logic             scl_o,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             busy,
    output logic             hs_armed,
    output logic [CFG_W-1:0] start_cfg
);

    scl_state_t state_q, state_d;
    logic              load;
    logic              expire;
    logic [SAMP_W-1:0] samp_m1;
    logic [STEP_W-1:0] step_m1;
    logic              scl_q, rise_q, fall_q;

    scl_timing_shadow #(
        .REG_W     (REG_W),
        .SAMP_W    (SAMP_W),
        .STEP_W    (STEP_W),
        .HS_STEP_W (HS_STEP_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (state_q == ST_IDLE),
        .hs_phase    (hs_phase),
        .rate_std_in (rate_std),
        .norm_in     (norm_timing),
        .hs_in       (hs_timing),
        .samp_m1     (samp_m1),
        .step_m1     (step_m1),
        .hs_armed    (hs_armed),
        .start_cfg   (start_cfg)
    );

    scl_half_counter #(
        .SAMP_W (SAMP_W),
        .STEP_W (STEP_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tick    (src_tick),
        .samp_m1 (samp_m1),
        .step_m1 (step_m1),
        .expire  (expire)
    );

    // next state and counter reload
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_HIGH;
                    load    = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    if (run) begin
                        state_d = ST_LOW;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_LOW: begin
                if (expire) begin
                    if (run) begin
                        state_d = ST_HIGH;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            scl_q  <= (state_d != ST_LOW);
            rise_q <= (state_q == ST_LOW) && expire;
            fall_q <= (state_q == ST_HIGH) && expire && run;
        end
    end

    assign scl_o    = scl_q;
    assign rise_stb = rise_q;
    assign fall_stb = fall_q;
    assign busy     = (state_q != ST_IDLE);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb)); // R3

    AST_FALL_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> !scl_o); // R3

    AST_RISE_GOES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> scl_o); // R3

    AST_EDGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |-> (rise_stb || fall_stb)); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> scl_o); // R7

endmodule

// File: tb/i2c_scl_timegen_tb.sv
module i2c_scl_timegen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_tick = 1'b1;
    logic        run = 1'b0;
    logic        hs_phase = 1'b0;
    logic        rate_std = 1'b0;
    logic [15:0] norm_timing = 16'h0000;
    logic [15:0] hs_timing = 16'h0000;
    logic        scl_o, rise_stb, fall_stb, busy, hs_armed;
    logic [15:0] start_cfg;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int cnt = 0;
    bit done = 1'b0;

    int    q_kind[$];
    int    q_len[$];
    string q_tag[$];

    always #10 clk = ~clk;

    i2c_scl_timegen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick    (src_tick),
        .run         (run),
        .hs_phase    (hs_phase),
        .rate_std    (rate_std),
        .norm_timing (norm_timing),
        .hs_timing   (hs_timing),
        .scl_o       (scl_o),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .busy        (busy),
        .hs_armed    (hs_armed),
        .start_cfg   (start_cfg)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int half_len(logic [15:0] n, logic [15:0] h, bit hsph);
        if (hsph && h[1:0] == 2'b11)
            return (int'(h[14:12]) + 1) * (int'(h[10:8]) + 1);
        return (int'(n[10:8]) + 1) * (int'(n[5:0]) + 1);
    endfunction

    task automatic push(int kind, int len, string tag);
        q_kind.push_back(kind);
        q_len.push_back(len);
        q_tag.push_back(tag);
    endtask

    // kind 0 = fall, 1 = rise; len -1 = don't care
    task automatic push_pairs(int k, int lh, int ll, bit dc_first, string tag);
        for (int i = 0; i < k; i++) begin
            push(0, (dc_first && i == 0) ? -1 : lh, tag);
            push(1, ll, tag);
        end
    endtask

    // source tick generator
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            src_tick = 1'b1;
        end else begin
            src_tick = (tick_ph == 0);
            tick_ph = (tick_ph + 1) % tick_div;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (rise_stb || fall_stb)) begin
            if (q_kind.size() == 0) begin
                chk(1'b0, "R3", "unexpected strobe", int'(rise_stb), -1);
            end else begin
                int k, l;
                string t;
                k = q_kind.pop_front();
                l = q_len.pop_front();
                t = q_tag.pop_front();
                chk(int'(rise_stb) == k, "R3", "strobe kind", int'(rise_stb), k);
                if (l >= 0) chk(cnt == l, t, "half-period cycles", cnt, l);
            end
            cnt = 1;
        end else if (busy) begin
            cnt++;
        end else begin
            cnt = 0;
        end
    end

    // run for k fall strobes; optional changes right after the first fall
    task automatic run_only(int k, int mid_norm, int mid_hsph, string tag);
        int falls = 0;
        bit cfg_pending = 1'b0;
        logic [15:0] old_cfg = 16'h0;
        @(negedge clk);
        run = 1'b1;
        while (falls < k) begin
            @(negedge clk);
            if (cfg_pending && busy) begin
                chk(start_cfg == old_cfg, "R6", "hold word frozen while busy",
                    int'(start_cfg), int'(old_cfg));
                cfg_pending = 1'b0;
            end
            if (fall_stb) begin
                falls++;
                if (falls == 1) begin
                    if (mid_norm >= 0) begin
                        old_cfg = start_cfg;
                        norm_timing = mid_norm[15:0];
                        rate_std = ~rate_std;
                        cfg_pending = 1'b1;
                    end
                    if (mid_hsph >= 0) hs_phase = mid_hsph[0];
                end
                if (falls == k) run = 1'b0;
            end
        end
        do @(negedge clk); while (busy);
        @(negedge clk);
        chk(q_kind.size() == 0, tag, "pending strobes after idle", q_kind.size(), 0);
        chk(scl_o == 1'b1, "R7", "scl high after idle", int'(scl_o), 1);
    endtask

    initial begin
        int n, h, m;
        repeat (3) @(negedge clk);
        chk(scl_o == 1'b1, "R1", "reset scl", int'(scl_o), 1);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(!rise_stb && !fall_stb, "R1", "reset strobes", int'({rise_stb, fall_stb}), 0);
        chk(hs_armed == 1'b0, "R1", "reset hs_armed", int'(hs_armed), 0);
        chk(start_cfg == 16'h1800, "R1", "reset hold word", int'(start_cfg), 'h1800);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: 2 x 3
        norm_timing = 16'h0102;
        n = half_len(norm_timing, hs_timing, 0);
        push_pairs(3, n, n, 0, "R2");
        run_only(3, -1, -1, "R2");

        // R2: 5 x 1
        norm_timing = 16'h0400;
        n = half_len(norm_timing, hs_timing, 0);
        push_pairs(2, n, n, 0, "R2");
        run_only(2, -1, -1, "R2");

        // R10: minimum 1 x 1
        norm_timing = 16'h0000;
        push_pairs(3, 1, 1, 0, "R10");
        run_only(3, -1, -1, "R10");

        // R10: maximum 8 x 64
        norm_timing = 16'h073F;
        n = half_len(norm_timing, hs_timing, 0);
        chk(n == 512, "R10", "max product", n, 512);
        push_pairs(1, n, n, 0, "R10");
        run_only(1, -1, -1, "R10");

        // R4: high-speed armed, 4 x 3
        norm_timing = 16'h1303;
        hs_timing = 16'h3203;
        hs_phase = 1'b1;
        h = half_len(norm_timing, hs_timing, 1);
        push_pairs(2, h, h, 0, "R4");
        run_only(2, -1, -1, "R4");
        chk(hs_armed == 1'b1, "R4", "hs_armed with key", int'(hs_armed), 1);

        // R4: key absent, normal fields apply
        hs_timing = 16'h3200;
        n = half_len(norm_timing, hs_timing, 1);
        chk(n == 16, "R4", "fallback length", n, 16);
        push_pairs(2, n, n, 0, "R4");
        run_only(2, -1, -1, "R4");
        chk(hs_armed == 1'b0, "R4", "hs_armed without key", int'(hs_armed), 0);

        // R5: mode switch takes effect at next half-period
        hs_timing = 16'h3203;
        hs_phase = 1'b0;
        n = half_len(norm_timing, hs_timing, 0);
        h = half_len(norm_timing, hs_timing, 1);
        push(0, n, "R5"); push(1, n, "R5");
        push(0, h, "R5"); push(1, h, "R5");
        run_only(2, -1, 1, "R5");
        hs_phase = 1'b0;
        hs_timing = 16'h0000;

        // R6: write during transfer ignored
        norm_timing = 16'h0102;
        rate_std = 1'b0;
        @(negedge clk);
        n = half_len(norm_timing, hs_timing, 0);
        push_pairs(3, n, n, 0, "R6");
        run_only(3, 16'h0000, -1, "R6");
        @(negedge clk);
        chk(start_cfg == 16'h8001, "R6", "hold word after idle", int'(start_cfg), 'h8001);
        push_pairs(1, 1, 1, 0, "R6");
        run_only(1, -1, -1, "R6");

        // R8: hold word follows rate while idle
        rate_std = 1'b0;
        repeat (2) @(negedge clk);
        chk(start_cfg == 16'h1800, "R8", "fast hold word", int'(start_cfg), 'h1800);
        rate_std = 1'b1;
        repeat (2) @(negedge clk);
        chk(start_cfg == 16'h8001, "R8", "standard hold word", int'(start_cfg), 'h8001);

        // R7: drop run during a high half-period
        norm_timing = 16'h0102;
        n = half_len(norm_timing, hs_timing, 0);
        push_pairs(1, n, n, 0, "R7");
        @(negedge clk);
        run = 1'b1;
        do @(negedge clk); while (!rise_stb);
        run = 1'b0;
        m = 1;
        @(negedge clk);
        while (busy) begin
            m++;
            @(negedge clk);
        end
        chk(m == n, "R7", "final high half-period cycles", m, n);
        repeat (2) @(negedge clk);
        chk(q_kind.size() == 0, "R7", "no strobe after high drop", q_kind.size(), 0);

        // R9: tick every third cycle, 2 x 2
        norm_timing = 16'h0101;
        tick_div = 3;
        n = half_len(norm_timing, hs_timing, 0) * 3;
        push_pairs(3, n, n, 1, "R9");
        run_only(3, -1, -1, "R9");
        tick_div = 1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule